// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level data cache. It pairs a direct-mapped main array with a small, fully associative victim buffer. A line leaves the main array when a refill needs its set. That line is not dropped: it moves into the victim buffer. The buffer is never filled from the next memory level.

When a request misses the main array, the victim buffer is searched before any next-level traffic starts. On a victim hit, the buffered line and the line in the conflicting set trade places, so a pair of addresses that share a set can both stay on chip. On a miss in both structures, the line is fetched into the main array. The line it displaces is parked in the victim buffer, in a free entry if there is one, otherwise in the least recently used entry. A dirty line pushed out of the buffer is written to the next level before the refill read is issued.

The processor side uses a hold-until-ready handshake. The caller keeps `req_valid` and the request fields steady until `rsp_ready` pulses. The next-level side issues one line-sized transaction at a time, and `mem_valid` completes it.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, `rsp_ready` and `mem_req` are low and every line of both structures is invalid, so the first access to any address causes a next-level refill.
- R2: A request that hits the main array asserts `rsp_ready` two rising edges after the request is first seen in the idle state, issues no next-level request and leaves the victim buffer unchanged.
- R3: A request that misses the main array but hits the victim buffer is served with no next-level request, with `rsp_ready` three rising edges after acceptance.
- R4: On a victim hit, the requested line moves into its main-array set and the line that was in that set takes over the victim entry. Afterwards a line is never present in both structures at once.
- R5: With two victim entries, an alternating sequence of two lines that share a set produces no next-level request once both lines have been loaded.
- R6: A miss in both structures issues a read (`mem_we`=0) whose `mem_addr` is the line address, meaning the word address shifted right by log2 of the words per line. The returned line is installed in the main array, and the request is then served from it.
- R7: On a refill, a valid displaced main-array line is written into the lowest-numbered invalid victim entry. If no entry is invalid, it replaces the least recently used entry.
- R8: An entry that receives a line, by insertion or by swap, becomes the most recently used entry. The relative order of the other entries does not change.
- R9: If the victim entry being replaced holds a dirty line, that line is written out (`mem_we`=1, `mem_addr` its line address, `mem_wline` its data with word k in bits k*DW upward) before the refill read.
- R10: A clean line pushed out of the victim buffer is discarded with no next-level write.
- R11: `rsp_ready` is high for exactly one cycle per request. A new request is accepted only while the block is idle.
- R12: A read returns the most recently written value of that word. Writes allocate on a miss, mark the line dirty and reach the next level only through a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until rsp_ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_ready |
| mem_req | output | 1 | Next-level transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | AW-log2(WORDS) | Line address of the transaction |
| mem_wline | output | WORDS*DW | Line written back |
| mem_rline | input | WORDS*DW | Line returned by the next level |
| mem_valid | input | 1 | Completes the current transaction |

## Verification
Several properties are checked on every cycle:
- The victim buffer holds no line twice.
- A line never sits in both the main array and the buffer.
- A main hit leaves the buffer untouched.
- A refill read never starts for a line the buffer holds.
- A write-back only targets a dirty entry.
- The ready pulse lasts one cycle.
- The age ordering always has exactly one oldest entry.

Other behaviour is only visible across whole scenarios, and the bench covers it with a reference model. That includes which entry is replaced, whether the line written back carries the latest data, the order of write-back and refill, and the absence of refills over the alternating two-line trace.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOK = 3'd1,
        ST_WB   = 3'd2,
        ST_FILL = 3'd3,
        ST_RESP = 3'd4
    } vc_state_e;

endpackage

// File: rtl/dmvc_lru.sv
// Age-based recency tracker: age 0 is most recent, N-1 is the replacement choice.
module dmvc_lru #(
    parameter int N = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       touch_en,
    input  logic [$clog2(N)-1:0]       touch_idx,
    output logic [$clog2(N)-1:0]       lru_idx
);
    localparam int AGW = $clog2(N);

    logic [N-1:0][AGW-1:0] age_d, age_q;
    logic [N-1:0]          oldest;

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (AGW'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + AGW'(1);
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest[i] = (age_q[i] == AGW'(N - 1));
            if (oldest[i]) lru_idx = AGW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= AGW'(i);
        end else begin
            age_q <= age_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest)); // R8

endmodule

// File: rtl/dmvc_vmatch.sv
// Fully associative line-address compare across all victim entries.
module dmvc_vmatch #(
    parameter int N   = 2,
    parameter int LAW = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              ent_valid,
    input  logic [N-1:0][LAW-1:0]     ent_laddr,
    input  logic [LAW-1:0]            key,
    output logic                      hit,
    output logic [$clog2(N)-1:0]      hit_idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_laddr[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |match;

    AST_VC_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R4

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
    import dmvc_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 16,
    parameter int SETS  = 4,
    parameter int WORDS = 2,
    parameter int VC_N  = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_we,
    input  logic [AW-1:0]                       req_addr,
    input  logic [DW-1:0]                       req_wdata,
    output logic                                rsp_ready,
    output logic [DW-1:0]                       rsp_rdata,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [AW-$clog2(WORDS)-1:0]         mem_addr,
    output logic [WORDS*DW-1:0]                 mem_wline,
    input  logic [WORDS*DW-1:0]                 mem_rline,
    input  logic                                mem_valid
);
    localparam int OFFW = $clog2(WORDS);
    localparam int IDXW = $clog2(SETS);
    localparam int LAW  = AW - OFFW;
    localparam int TW   = LAW - IDXW;
    localparam int LW   = WORDS * DW;
    localparam int VIW  = $clog2(VC_N);

    typedef struct packed {
        vc_state_e                   st;
        logic                        we;
        logic [LAW-1:0]              la;
        logic [OFFW-1:0]             off;
        logic [DW-1:0]               wdata;
        logic [DW-1:0]               rdata;
        logic [SETS-1:0]             mv;
        logic [SETS-1:0]             md;
        logic [SETS-1:0][TW-1:0]     mtag;
        logic [SETS-1:0][LW-1:0]     mdat;
        logic [VC_N-1:0]             vv;
        logic [VC_N-1:0]             vd;
        logic [VC_N-1:0][LAW-1:0]    vla;
        logic [VC_N-1:0][LW-1:0]     vdat;
        logic [VIW-1:0]              slot;
    } state_t;

    state_t q, d;

    logic [IDXW-1:0] set_idx;
    logic [TW-1:0]   tag;
    logic            main_hit;
    logic            vhit;
    logic [VIW-1:0]  vidx;
    logic [VIW-1:0]  lru_idx;
    logic [VIW-1:0]  ins_idx;
    logic            touch_en;
    logic [VIW-1:0]  touch_idx;
    logic            evict;
    logic [VIW-1:0]  evict_idx;
    logic [LW-1:0]   hit_line;

    assign set_idx  = q.la[IDXW-1:0];
    assign tag      = q.la[LAW-1:IDXW];
    assign main_hit = q.mv[set_idx] && (q.mtag[set_idx] == tag);

    dmvc_vmatch #(.N(VC_N), .LAW(LAW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (q.vv),
        .ent_laddr (q.vla),
        .key       (q.la),
        .hit       (vhit),
        .hit_idx   (vidx)
    );

    dmvc_lru #(.N(VC_N)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    // Insertion target: lowest free entry, else the oldest one.
    always_comb begin
        logic found;
        found   = 1'b0;
        ins_idx = lru_idx;
        for (int i = 0; i < VC_N; i++) begin
            if (!q.vv[i] && !found) begin
                ins_idx = VIW'(i);
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        d         = q;
        touch_en  = 1'b0;
        touch_idx = '0;
        evict     = 1'b0;
        evict_idx = ins_idx;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.la;
        mem_wline = q.vdat[q.slot];
        rsp_ready = 1'b0;
        hit_line  = q.mdat[set_idx];

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_LOOK;
                    d.we    = req_we;
                    d.la    = req_addr[AW-1:OFFW];
                    d.off   = req_addr[OFFW-1:0];
                    d.wdata = req_wdata;
                end
            end
            ST_LOOK: begin
                if (main_hit) begin
                    if (q.we) begin
                        hit_line[q.off*DW +: DW] = q.wdata;
                        d.mdat[set_idx] = hit_line;
                        d.md[set_idx]   = 1'b1;
                        d.rdata         = q.wdata;
                    end else begin
                        d.rdata = hit_line[q.off*DW +: DW];
                    end
                    d.st = ST_RESP;
                end else if (vhit) begin
                    d.mdat[set_idx] = q.vdat[vidx];
                    d.mtag[set_idx] = tag;
                    d.mv[set_idx]   = 1'b1;
                    d.md[set_idx]   = q.vd[vidx];
                    d.vla[vidx]     = {q.mtag[set_idx], set_idx};
                    d.vdat[vidx]    = q.mdat[set_idx];
                    d.vd[vidx]      = q.md[set_idx];
                    d.vv[vidx]      = q.mv[set_idx];
                    touch_en        = q.mv[set_idx];
                    touch_idx       = vidx;
                    d.st            = ST_LOOK;
                end else if (q.mv[set_idx]) begin
                    d.slot = ins_idx;
                    if (q.vv[ins_idx] && q.vd[ins_idx]) begin
                        d.st = ST_WB;
                    end else begin
                        evict = 1'b1;
                        d.st  = ST_FILL;
                    end
                end else begin
                    d.st = ST_FILL;
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.vla[q.slot];
                if (mem_valid) begin
                    evict     = 1'b1;
                    evict_idx = q.slot;
                    d.st      = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_valid) begin
                    d.mdat[set_idx] = mem_rline;
                    d.mtag[set_idx] = tag;
                    d.mv[set_idx]   = 1'b1;
                    d.md[set_idx]   = 1'b0;
                    d.st            = ST_LOOK;
                end
            end
            ST_RESP: begin
                rsp_ready = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        // Park the displaced main line in the chosen victim entry.
        if (evict) begin
            d.vla[evict_idx]  = {q.mtag[set_idx], set_idx};
            d.vdat[evict_idx] = q.mdat[set_idx];
            d.vd[evict_idx]   = q.md[set_idx];
            d.vv[evict_idx]   = 1'b1;
            d.mv[set_idx]     = 1'b0;
            touch_en          = 1'b1;
            touch_idx         = evict_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_rdata = q.rdata;

    AST_HIT_KEEPS_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOOK && main_hit) |=> ($stable(q.vv) && $stable(q.vla) && $stable(q.vdat))); // R2
    AST_VHIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOOK && !main_hit && vhit) |=> (q.st == ST_LOOK && !mem_req)); // R3
    AST_READ_ONLY_ON_VMISS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !vhit); // R3
    AST_LINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOOK) |-> !(main_hit && vhit)); // R4
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (q.vv[q.slot] && q.vd[q.slot])); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R11

endmodule

// File: tb/tb_dm_victim_cache.sv
`timescale 1ns/1ps
module tb_dm_victim_cache;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int SETS  = 4;
    localparam int WORDS = 2;
    localparam int VC_N  = 2;
    localparam int OFFW  = $clog2(WORDS);
    localparam int LAW   = AW - OFFW;
    localparam int LW    = WORDS * DW;
    localparam int NW    = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_ready;
    logic [DW-1:0] rsp_rdata;
    logic mem_req, mem_we;
    logic [LAW-1:0] mem_addr;
    logic [LW-1:0] mem_wline;
    logic [LW-1:0] mem_rline = '0;
    logic mem_valid = 1'b0;

    always #2 clk = ~clk;

    dm_victim_cache #(.AW(AW), .DW(DW), .SETS(SETS), .WORDS(WORDS), .VC_N(VC_N)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
        .mem_valid(mem_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_mem [NW];
    logic [DW-1:0] shadow  [NW];

    // Reference state of the cache, derived from the requirements.
    bit bm_v [SETS];
    int bm_la[SETS];
    bit bm_d [SETS];
    bit vv   [VC_N];
    int vla  [VC_N];
    bit vd   [VC_N];
    int vage [VC_N];

    int rd_cnt = 0, wb_cnt = 0, now = 0;
    int last_rd_la = -1, last_wb_la = -1, last_rd_t = 0, last_wb_t = 0;
    logic [LW-1:0] last_wb_line = '0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic touch(input int e);
        for (int i = 0; i < VC_N; i++)
            if (i != e && vage[i] < vage[e]) vage[i]++;
        vage[e] = 0;
    endtask

    task automatic model_step(input int la, input bit we, output int kind,
                              output int ewb, output int ewb_la, output bit dropc);
        int s, v, e, t_la;
        bit t_d;
        s = la % SETS; v = -1; e = -1;
        ewb = 0; ewb_la = 0; dropc = 0;
        if (bm_v[s] && bm_la[s] == la) begin
            kind = 0;
            if (we) bm_d[s] = 1;
        end else begin
            for (int i = 0; i < VC_N; i++) if (vv[i] && vla[i] == la) v = i;
            if (v >= 0) begin
                kind = 1;
                t_la = vla[v]; t_d = vd[v];
                vla[v] = bm_la[s]; vd[v] = bm_d[s]; vv[v] = bm_v[s];
                bm_la[s] = t_la; bm_d[s] = t_d | we; bm_v[s] = 1;
                touch(v);
            end else begin
                kind = 2;
                if (bm_v[s]) begin
                    for (int i = 0; i < VC_N; i++) if (!vv[i] && e < 0) e = i;
                    if (e < 0) for (int i = 0; i < VC_N; i++) if (vage[i] == VC_N - 1) e = i;
                    if (vv[e]) begin
                        if (vd[e]) begin ewb = 1; ewb_la = vla[e]; end
                        else dropc = 1;
                    end
                    vla[e] = bm_la[s]; vd[e] = bm_d[s]; vv[e] = 1;
                    touch(e);
                end
                bm_v[s] = 1; bm_la[s] = la; bm_d[s] = we;
            end
        end
    endtask

    // Next-level memory: two-cycle response, one transaction at a time.
    initial begin
        int wc;
        wc = 0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (mem_req) begin
                if (wc == 1) begin
                    wc = 0;
                    if (mem_we) begin
                        for (int w = 0; w < WORDS; w++)
                            ref_mem[int'(mem_addr) * WORDS + w] = mem_wline[w*DW +: DW];
                        wb_cnt++; last_wb_la = int'(mem_addr); last_wb_t = now;
                        last_wb_line = mem_wline;
                    end else begin
                        for (int w = 0; w < WORDS; w++)
                            mem_rline[w*DW +: DW] = ref_mem[int'(mem_addr) * WORDS + w];
                        rd_cnt++; last_rd_la = int'(mem_addr); last_rd_t = now;
                    end
                    mem_valid = 1'b1;
                end else begin
                    wc++;
                end
            end
        end
    end

    always @(posedge clk) now <= now + 1;

    int m_cyc, m_rd, m_wb;

    task automatic access(input int la, input int off, input bit we, input logic [DW-1:0] data);
        int kind, ewb, ewb_la, addr, rd0, wb0;
        bit dropc;
        string rq;
        logic [LW-1:0] exp_line;
        addr = la * WORDS + off;
        model_step(la, we, kind, ewb, ewb_la, dropc);
        rd0 = rd_cnt; wb0 = wb_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = data;
        m_cyc = 0;
        forever begin
            @(posedge clk);
            m_cyc++;
            @(negedge clk);
            if (rsp_ready) break;
        end
        req_valid = 1'b0;
        m_rd = rd_cnt - rd0; m_wb = wb_cnt - wb0;
        if (!we) check(rsp_rdata == shadow[addr], "R12", "read data", rsp_rdata, shadow[addr]);
        if (kind == 0) begin
            check(m_cyc == 2, "R2", "main hit latency", m_cyc, 2);
            check(m_rd + m_wb == 0, "R2", "main hit traffic", m_rd + m_wb, 0);
        end else if (kind == 1) begin
            check(m_cyc == 3, "R3", "victim hit latency", m_cyc, 3);
            check(m_rd + m_wb == 0, "R3", "victim hit traffic", m_rd + m_wb, 0);
        end else begin
            check(m_rd == 1, "R6", "refill count", m_rd, 1);
            check(last_rd_la == la, "R6", "refill line address", last_rd_la, la);
            rq = (ewb != 0) ? "R9" : "R10";
            check(m_wb == ewb, rq, "write-back count", m_wb, ewb);
            if (ewb != 0) begin
                for (int w = 0; w < WORDS; w++) exp_line[w*DW +: DW] = shadow[ewb_la * WORDS + w];
                check(last_wb_la == ewb_la, "R9", "write-back address", last_wb_la, ewb_la);
                check(last_wb_line == exp_line, "R9", "write-back data", last_wb_line, exp_line);
                check(last_wb_t < last_rd_t, "R9", "write-back before refill", last_wb_t, last_rd_t);
            end
        end
        if (we) shadow[addr] = data;
        @(negedge clk);
        check(rsp_ready == 1'b0, "R11", "ready pulse width", rsp_ready, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        int la, pa, qa, ma, na, a, b, r0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) begin
            ref_mem[i] = DW'(i * 7 + 3) ^ 16'h5a00;
            shadow[i]  = ref_mem[i];
        end
        for (int i = 0; i < SETS; i++) begin bm_v[i] = 0; bm_la[i] = 0; bm_d[i] = 0; end
        for (int i = 0; i < VC_N; i++) begin vv[i] = 0; vla[i] = 0; vd[i] = 0; vage[i] = i; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_ready == 1'b0, "R1", "ready after reset", rsp_ready, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        rst_n = 1'b1;

        // Replacement order in set 2: P, Q (dirty), M, then a swap and a fresh miss.
        pa = 2; qa = 2 + SETS; ma = 2 + 2 * SETS; na = 2 + 3 * SETS;
        access(pa, 0, 0, '0);
        check(m_rd == 1, "R1", "first access refills", m_rd, 1);
        access(qa, 1, 1, 16'hbeef);   // P into a free entry
        check(m_wb == 0, "R7", "insert into free entry", m_wb, 0);
        access(ma, 0, 0, '0);         // Q into the other free entry
        access(pa, 0, 0, '0);         // victim hit, M now most recent
        check(m_cyc == 3 && m_rd == 0, "R4", "swapped line served", m_cyc, 3);
        access(na, 1, 0, '0);         // P displaced, Q (oldest, dirty) written back
        check(m_wb == 1 && last_wb_la == qa, "R7", "oldest entry replaced", last_wb_la, qa);
        access(ma, 0, 0, '0);         // M survived: swap made it most recent
        check(m_cyc == 3 && m_rd == 0, "R8", "recent entry kept", m_rd, 0);
        access(qa, 1, 0, '0);         // Q must return from next level with its write
        check(m_rd == 1, "R8", "dropped entry refetched", m_rd, 1);

        // Two lines sharing set 1, alternated.
        a = 1; b = 1 + SETS;
        access(a, 0, 0, '0);
        access(b, 0, 0, '0);
        r0 = rd_cnt;
        for (int k = 0; k < 8; k++) begin
            access((k % 2 == 0) ? a : b, k % 2, k % 3 == 0, DW'(k * 33 + 1));
            check(m_cyc == 3, "R5", "alternating access swaps", m_cyc, 3);
        end
        check(rd_cnt == r0, "R5", "no refills over trace", rd_cnt - r0, 0);
        access(b, 0, 0, '0);
        check(m_cyc == 2, "R2", "repeat access hits main", m_cyc, 2);

        // Random mix over twelve lines that collide heavily.
        for (int n = 0; n < 300; n++) begin
            la = int'($urandom % 3) * SETS * 5 + int'($urandom % SETS);
            access(la, int'($urandom % WORDS), ($urandom % 3) == 0, DW'($urandom));
        end
        finish_run();
    end
endmodule